// File: doc/BRIEF.md
# Dual-Rate Serializer with Comma Test Pattern

This block turns a 20-bit parallel word into a single serial bit stream. It runs on one fast clock, and a bit enable marks every serial bit slot. The word is treated as two 10-bit symbols. At full rate all 20 bits of each word go out. At half rate only one 10-bit symbol goes out per word, and a select input chooses the lower or the upper symbol. A ping-pong option, which applies only at full rate, takes the upper symbol half a word later than the lower one. Upstream logic can therefore present the two halves one after the other.

A test-pattern input replaces the data with the K28.5 comma symbol. The comma either alternates between its two running-disparity forms or repeats the positive-disparity form. The block also gives a one-cycle word-start pulse that stands in for the parallel byte clock. An active-low clear input restarts the internal bit counter at any time.

Top module: `ser_dual_rate`

## Requirements
- R1: With `rate_full` high, each word sends 20 bits: `tx_word` bit 0 first and bit 19 last.
- R2: With `rate_full` low, each word sends 10 bits. `byte_hi` low sends bits 0 to 9 in that order. `byte_hi` high sends bits 10 to 19 in that order.
- R3: The data and all mode inputs are sampled on the enabled edge that starts a word. Changes to them during the rest of the word have no effect on that word.
- R4: With `rate_full` and `ping_pong` both high, bits 0 to 9 are sampled at word start. Bits 10 to 19 are sampled on the enabled edge that sends bit 10.
- R5: `bclk_en` pulses for exactly one cycle on the edge that starts each word. The pulse is suppressed for words that start with `rate_full` low and `ping_pong` high.
- R6: With `tpat_en` high and `tpat_fixed` low, the output is K28.5 with alternating disparity. The symbols alternate 0011111010 and 1100000101, each written in transmission order, first bit leftmost. The first symbol after reset or clear is 0011111010.
- R7: With `tpat_en` and `tpat_fixed` both high, every 10-bit symbol is 0011111010, in transmission order.
- R8: While `clr_n` is low, `ser_valid` and `bclk_en` are low and the bit counter is zeroed. The first enabled edge after release starts a new word at bit 0.
- R9: `ser_valid` is high for one cycle after each enabled edge. `ser_out` changes only on enabled edges.
- R10: During reset, `ser_out`, `ser_valid` and `bclk_en` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| clr_n | input | 1 | Active-low synchronous clear of the bit counter and pattern phase |
| bit_en | input | 1 | Bit slot enable; one serial bit per enabled edge |
| tx_word | input | 20 | Parallel word, lower symbol in bits 9:0 |
| rate_full | input | 1 | 1 = 20 bits per word, 0 = 10 bits per word |
| byte_hi | input | 1 | Half rate only: 1 selects bits 19:10 |
| ping_pong | input | 1 | Full rate only: upper symbol sampled at mid-word |
| tpat_en | input | 1 | Replace data with K28.5 |
| tpat_fixed | input | 1 | 1 = repeat positive-disparity K28.5, 0 = alternate |
| ser_out | output | 1 | Serial data bit |
| ser_valid | output | 1 | Marks a new bit on `ser_out` |
| bclk_en | output | 1 | Word-start pulse standing in for the byte clock |

## Verification
Each serial bit appears on `ser_out` and `ser_valid` one register stage after the enabled rising edge that selects it. `bclk_en` rises after the same edge that loads the word. The bench therefore samples every bit on the falling edge that follows the enabled rising edge, and it counts `bclk_en` over those same samples. The ping-pong upper half is driven on the falling edge just before the edge that sends bit 10, and it is scrambled right after that edge. The word inputs are scrambled one falling edge after the load, so any late sampling becomes visible. After reset is released the bench waits out the two synchronizer edges. After a clear it expects bit 0 on the first enabled edge.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;
  localparam int unsigned SYM_W = 10;

  // K28.5 symbols, index i = i-th transmitted bit
  localparam logic [SYM_W-1:0] K_RDP = 10'b0101111100; // sent 0011111010
  localparam logic [SYM_W-1:0] K_RDN = 10'b1010000011; // sent 1100000101

  typedef struct packed {
    logic full;
    logic hi_sel;
    logic pp;
    logic tpat;
    logic tfix;
  } ser_mode_t;
endpackage

// File: rtl/ser_bit_counter.sv
`timescale 1ns/1ps
module ser_bit_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             bit_en,
  input  logic [CNT_W-1:0] last_idx,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!clr_n) begin
      cnt_d = '0;
    end else if (bit_en) begin
      if (cnt_q == last_idx) cnt_d = '0;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ser_word_capture.sv
`timescale 1ns/1ps
module ser_word_capture
  import ser_pkg::*;
#(
  parameter  int unsigned SYM_W  = 10,
  localparam int unsigned WORD_W = 2 * SYM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              hi_load,
  input  logic [WORD_W-1:0] word_in,
  input  ser_mode_t         mode_in,
  output logic [WORD_W-1:0] word_view,
  output ser_mode_t         mode_eff
);
  logic [WORD_W-1:0] word_q, word_d;
  ser_mode_t         mode_q, mode_d;

  // next state doubles as the view of the current slot
  always_comb begin
    word_d = word_q;
    mode_d = mode_q;
    if (load) begin
      word_d = word_in;
      mode_d = mode_in;
    end else if (hi_load) begin
      word_d[WORD_W-1:SYM_W] = word_in[WORD_W-1:SYM_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      mode_q <= '0;
    end else begin
      word_q <= word_d;
      mode_q <= mode_d;
    end
  end

  assign word_view = word_d;
  assign mode_eff  = mode_d;
endmodule

// File: rtl/ser_kcode_gen.sv
`timescale 1ns/1ps
module ser_kcode_gen
  import ser_pkg::*;
#(
  parameter int unsigned SYM_W = 10,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             adv,
  input  logic             fixed,
  input  logic [CNT_W-1:0] sym_pos,
  output logic             k_bit
);
  localparam logic [SYM_W-1:0] SYM_P = SYM_W'(K_RDP);
  localparam logic [SYM_W-1:0] SYM_N = SYM_W'(K_RDN);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(SYM_W - 1);

  logic             phase_q, phase_d;
  logic [SYM_W-1:0] sym;

  always_comb begin
    phase_d = phase_q;
    if (!clr_n)                         phase_d = 1'b0;
    else if (adv && (sym_pos == LAST))  phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  always_comb begin
    if (fixed || !phase_q) sym = SYM_P;
    else                   sym = SYM_N;
    k_bit = sym[sym_pos];
  end
endmodule

// File: rtl/ser_dual_rate.sv
`timescale 1ns/1ps
module ser_dual_rate
  import ser_pkg::*;
#(
  parameter  int unsigned SYM_W  = ser_pkg::SYM_W,
  localparam int unsigned WORD_W = 2 * SYM_W,
  localparam int unsigned CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              bit_en,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              rate_full,
  input  logic              byte_hi,
  input  logic              ping_pong,
  input  logic              tpat_en,
  input  logic              tpat_fixed,
  output logic              ser_out,
  output logic              ser_valid,
  output logic              bclk_en
);
  localparam logic [CNT_W-1:0] SYM_C  = CNT_W'(SYM_W);
  localparam logic [CNT_W-1:0] LAST_H = CNT_W'(SYM_W - 1);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(WORD_W - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  logic [CNT_W-1:0]  cnt, last_idx, idx, sym_pos;
  logic              load, hi_load;
  ser_mode_t         mode_in, mode_eff;
  logic [WORD_W-1:0] word_view;
  logic              data_bit, k_bit, tx_bit;

  always_comb begin
    mode_in.full   = rate_full;
    mode_in.hi_sel = byte_hi;
    mode_in.pp     = ping_pong;
    mode_in.tpat   = tpat_en;
    mode_in.tfix   = tpat_fixed;
  end

  assign load     = clr_n & bit_en & (cnt == '0);
  assign hi_load  = clr_n & bit_en & mode_eff.full & mode_eff.pp & (cnt == SYM_C);
  assign last_idx = mode_eff.full ? LAST_F : LAST_H;

  ser_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr_n    (clr_n),
    .bit_en   (bit_en),
    .last_idx (last_idx),
    .cnt      (cnt)
  );

  ser_word_capture #(.SYM_W(SYM_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (load),
    .hi_load   (hi_load),
    .word_in   (tx_word),
    .mode_in   (mode_in),
    .word_view (word_view),
    .mode_eff  (mode_eff)
  );

  always_comb begin
    if (mode_eff.full)        idx = cnt;
    else if (mode_eff.hi_sel) idx = cnt + SYM_C;
    else                      idx = cnt;
    if (cnt >= SYM_C) sym_pos = cnt - SYM_C;
    else              sym_pos = cnt;
    data_bit = word_view[idx];
  end

  ser_kcode_gen #(.SYM_W(SYM_W), .CNT_W(CNT_W)) u_kgen (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr_n   (clr_n),
    .adv     (bit_en & mode_eff.tpat),
    .fixed   (mode_eff.tfix),
    .sym_pos (sym_pos),
    .k_bit   (k_bit)
  );

  assign tx_bit = mode_eff.tpat ? k_bit : data_bit;

  // output stage
  logic out_d, valid_d, bclk_d;
  logic out_q, valid_q, bclk_q;

  always_comb begin
    out_d   = out_q;
    valid_d = 1'b0;
    bclk_d  = 1'b0;
    if (!clr_n) begin
      out_d = 1'b0;
    end else if (bit_en) begin
      out_d   = tx_bit;
      valid_d = 1'b1;
      bclk_d  = load & ~(~mode_eff.full & mode_eff.pp);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_q   <= 1'b0;
      valid_q <= 1'b0;
      bclk_q  <= 1'b0;
    end else begin
      out_q   <= out_d;
      valid_q <= valid_d;
      bclk_q  <= bclk_d;
    end
  end

  assign ser_out   = out_q;
  assign ser_valid = valid_q;
  assign bclk_en   = bclk_q;
endmodule

// File: rtl/ser_dual_rate_chk.sv
`timescale 1ns/1ps
module ser_dual_rate_chk (
  input logic clk,
  input logic rst_n,
  input logic clr_n,
  input logic bit_en,
  input logic rate_full,
  input logic ping_pong,
  input logic ser_out,
  input logic ser_valid,
  input logic bclk_en
);
  // R9
  a_r9_valid_tracks_en: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && bit_en) |=> ser_valid);
  // R9
  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !ser_valid);
  // R9
  a_r9_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !bit_en) |=> $stable(ser_out));
  // R8
  a_r8_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (!ser_valid && !bclk_en));
  // R5
  a_r5_bclk_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_en |-> ser_valid);
  // R5
  a_r5_bclk_mode: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_en |-> $past(rate_full || !ping_pong));
endmodule

bind ser_dual_rate ser_dual_rate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .clr_n     (clr_n),
  .bit_en    (bit_en),
  .rate_full (rate_full),
  .ping_pong (ping_pong),
  .ser_out   (ser_out),
  .ser_valid (ser_valid),
  .bclk_en   (bclk_en)
);

// File: tb/ser_dual_rate_tb.sv
`timescale 1ns/1ps
module ser_dual_rate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, clr_n, bit_en;
  logic [19:0] tx_word;
  logic        rate_full, byte_hi, ping_pong, tpat_en, tpat_fixed;
  logic        ser_out, ser_valid, bclk_en;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ser_dual_rate u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .bit_en(bit_en),
    .tx_word(tx_word), .rate_full(rate_full), .byte_hi(byte_hi),
    .ping_pong(ping_pong), .tpat_en(tpat_en), .tpat_fixed(tpat_fixed),
    .ser_out(ser_out), .ser_valid(ser_valid), .bclk_en(bclk_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {full, hi, pp, gap, word[19:0], pp_upper[9:0]}
  localparam logic [33:0] VEC [9] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 20'hA5C3E, 10'h000},
    {1'b1, 1'b0, 1'b0, 1'b0, 20'h00001, 10'h000},
    {1'b1, 1'b0, 1'b0, 1'b0, 20'h80000, 10'h000},
    {1'b0, 1'b0, 1'b0, 1'b0, 20'hF0E1D, 10'h000},
    {1'b0, 1'b1, 1'b0, 1'b0, 20'hF0E1D, 10'h000},
    {1'b1, 1'b0, 1'b1, 1'b0, 20'h12345, 10'h2AA},
    {1'b0, 1'b0, 1'b1, 1'b0, 20'h5A5A5, 10'h000},
    {1'b1, 1'b0, 1'b0, 1'b1, 20'h6B1C4, 10'h000},
    {1'b0, 1'b1, 1'b0, 1'b1, 20'h3C96E, 10'h000}
  };

  function automatic logic [9:0] sym_from(input string s);
    logic [9:0] v;
    for (int i = 0; i < 10; i++) v[i] = (s[i] == "1");
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_word(input logic f, h, p, g, t, x,
                          input logic [19:0] w, input logic [9:0] ph,
                          output logic [19:0] got, output int bc, output int vbad);
    int n;
    n = f ? 20 : 10;
    got = '0; bc = 0; vbad = 0;
    rate_full = f; byte_hi = h; ping_pong = p; tpat_en = t; tpat_fixed = x;
    bit_en = 1'b1;
    tx_word = (f && p) ? {~ph, w[9:0]} : w;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got[i] = ser_out;
      bc += int'(bclk_en);
      if (!ser_valid) vbad++;
      if (i == 0) begin  // R3: disturb everything after the load edge
        rate_full = ~f; byte_hi = ~h; ping_pong = ~p; tpat_en = ~t; tpat_fixed = ~x;
        tx_word[9:0] = ~tx_word[9:0];
        if (!(f && p)) tx_word[19:10] = ~tx_word[19:10];
      end
      if (f && p && i == 9)  tx_word[19:10] = ph;
      if (f && p && i == 10) tx_word[19:10] = ~ph;
      if (g) begin
        bit_en = 1'b0;
        @(negedge clk);
        if (ser_valid) vbad++;
        if (ser_out !== got[i]) vbad++;
        bc += int'(bclk_en);
        bit_en = 1'b1;
      end
    end
  endtask

  task automatic pulse_clear();
    clr_n = 1'b0;
    @(negedge clk);
    chk(!ser_valid && !bclk_en, "R8", "quiet during clear",
        {18'd0, ser_valid, bclk_en}, 20'd0);
    clr_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] got, exp;
    int          bc, vbad, n;
    logic [9:0]  kp, kn;
    string       req;
    kp = sym_from("0011111010");
    kn = sym_from("1100000101");

    rst_n = 1'b0; clr_n = 1'b1; bit_en = 1'b0; tx_word = '0;
    rate_full = 1'b0; byte_hi = 1'b0; ping_pong = 1'b0; tpat_en = 1'b0; tpat_fixed = 1'b0;
    repeat (3) @(negedge clk);
    chk(ser_out == 1'b0,   "R10", "ser_out in reset",   {19'd0, ser_out},   20'd0);
    chk(ser_valid == 1'b0, "R10", "ser_valid in reset", {19'd0, ser_valid}, 20'd0);
    chk(bclk_en == 1'b0,   "R10", "bclk_en in reset",   {19'd0, bclk_en},   20'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ser_valid == 1'b0, "R9", "no bit without enable", {19'd0, ser_valid}, 20'd0);

    // table walk: R1 R2 R3 R4 R5 R9
    foreach (VEC[k]) begin
      logic f, h, p, g;
      logic [19:0] w;
      logic [9:0]  ph;
      {f, h, p, g, w, ph} = VEC[k];
      run_word(f, h, p, g, 1'b0, 1'b0, w, ph, got, bc, vbad);
      n = f ? 20 : 10;
      if (f) exp = p ? {ph, w[9:0]} : w;
      else   exp = {10'd0, (h ? w[19:10] : w[9:0])};
      if (f && p) req = "R4,R3";
      else if (f) req = "R1,R3";
      else        req = "R2,R3";
      chk(got == exp, req, $sformatf("vector %0d bits", k), got, exp);
      chk(bc == ((f || !p) ? 1 : 0), "R5", $sformatf("vector %0d word pulse", k),
          20'(bc), 20'((f || !p) ? 1 : 0));
      chk(vbad == 0, "R9", $sformatf("vector %0d valid/hold", k), 20'(vbad), 20'd0);
      if (n == 0) errors++;
    end

    // R8: clear in the middle of a word
    rate_full = 1'b1; byte_hi = 1'b0; ping_pong = 1'b0; tpat_en = 1'b0;
    tx_word = 20'hFFFFF; bit_en = 1'b1;
    repeat (5) @(negedge clk);
    pulse_clear();
    run_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h3A6D9, 10'd0, got, bc, vbad);
    chk(got == 20'h3A6D9, "R8", "first word after clear", got, 20'h3A6D9);

    // R6: alternating comma at half rate, starts positive after clear
    pulse_clear();
    for (int j = 0; j < 4; j++) begin
      run_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 10'd0, got, bc, vbad);
      exp = {10'd0, (j % 2 == 0) ? kp : kn};
      chk(got == exp, "R6", $sformatf("half-rate comma %0d", j), got, exp);
    end

    // R6: full rate carries both forms per word
    pulse_clear();
    for (int j = 0; j < 2; j++) begin
      run_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0F0F0, 10'd0, got, bc, vbad);
      chk(got == {kn, kp}, "R6", $sformatf("full-rate comma %0d", j), got, {kn, kp});
    end

    // R7: fixed-disparity comma
    pulse_clear();
    for (int j = 0; j < 2; j++) begin
      run_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 20'h00000, 10'd0, got, bc, vbad);
      chk(got == {kp, kp}, "R7", $sformatf("fixed comma full %0d", j), got, {kp, kp});
    end
    for (int j = 0; j < 2; j++) begin
      run_word(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 20'hFFFFF, 10'd0, got, bc, vbad);
      chk(got == {10'd0, kp}, "R7", $sformatf("fixed comma half %0d", j), got, {10'd0, kp});
    end

    bit_en = 1'b0;
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule